// File: doc/BRIEF.md
# EDID Fetch and Checksum Engine

This block pulls the display identification data out of an attached sink and decides whether it can be trusted. A single start pulse launches the sequence. The engine first reads a short capability region from the sink over an auxiliary register port. It then reads the extension-count byte from the identification device over a byte-read port. Next it streams the base block, and the extension block when the count is nonzero, through a running 8-bit sum. A block is accepted only when its sum wraps to zero.

A read error or a bad sum ends the current attempt, and the whole fetch starts again from the extension-count read, with a bounded number of attempts. After a good fetch the engine reads the sink's test-request register. When the sink asks for an identification-read test, the engine writes back the checksum byte of the last block it fetched, followed by a response code. A one-cycle done pulse reports pass or fail, the number of attempts used and the last checksum byte seen. The bus transactions themselves sit outside the block, behind two request/done ports that each allow only one request in flight.

Top module: `edid_fetch`

## Requirements
- R1: While reset is held and after it is released, `done`, `pass`, `rd_req` and `aux_req` are 0 and `tries` is 0.
- R2: After a start pulse in the idle state, the engine first issues exactly CAP_BYTES (12) auxiliary reads at consecutive addresses beginning at CAP_BASE (0x00000). It issues them once per start, before any identification-device read.
- R3: Every identification read is addressed to device 0x50. The first read of every attempt fetches offset BLOCK_BYTES-2 (126), which holds the extension count.
- R4: The base block is read at offsets 0 to BLOCK_BYTES-1 (0..127) in ascending order. It passes only if the modulo-256 sum of its bytes is zero.
- R5: When the extension count is nonzero (any nonzero value), the block at offsets 128 to 255 is fetched and checked after the base block passes. When the count is zero, no offset above 127 is read.
- R6: A read returned with `rd_err` high, or a block with a nonzero sum, aborts the attempt. A new attempt begins at the extension-count read, up to MAX_TRIES (3) attempts in total. The first successful attempt ends the sequence.
- R7: After a successful fetch, one auxiliary read of address 0x00218 is made. If bit 2 of the returned byte is set, the checksum byte (offset 127 of the last block fetched) is written to 0x00261, and then code 0x04 is written to 0x00260. If bit 2 is clear, no write is made, whatever the other bits hold.
- R8: `done` is high for exactly one cycle per sequence, together with `pass`, `tries` (attempts used, 1 to MAX_TRIES) and `csum` (the last byte at a block's final offset that was returned).
- R9: At most one request is outstanding: `rd_req` and `aux_req` are never high together. A request and its address stay unchanged until its `done` strobe.
- R10: A start pulse while a sequence is running has no effect: it causes no extra `done` pulse and no extra reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one fetch sequence when idle |
| rd_req | output | 1 | Identification byte read request, held until `rd_done` |
| rd_dev | output | 7 | Target device address |
| rd_off | output | 8 | Byte offset to read |
| rd_data | input | 8 | Returned byte, valid with `rd_done` |
| rd_err | input | 1 | Read failed, valid with `rd_done` |
| rd_done | input | 1 | Single-cycle completion of the read request |
| aux_req | output | 1 | Auxiliary register request, held until `aux_done` |
| aux_wr | output | 1 | 1 for a write, 0 for a read |
| aux_addr | output | 20 | Auxiliary register address |
| aux_wdata | output | 8 | Write data |
| aux_rdata | input | 8 | Read data, valid with `aux_done` |
| aux_done | input | 1 | Single-cycle completion of the auxiliary request |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pass | output | 1 | Sequence result, valid with `done` |
| tries | output | 2 | Attempts used |
| csum | output | 8 | Last block checksum byte returned |

## Verification
The bench builds the engine with its default parameters: 128-byte blocks, three attempts and a 12-byte capability region. This keeps the extension byte at offset 126, the checksum byte at 127 and the extension block's offsets running up to 255 in the 8-bit offset space. With these values the bench can reach a failure on the third and final attempt, a retry that starts deep inside the extension block, and a full 771-read failing run. The sink model holds each request for two cycles, so stray start pulses and request-hold behaviour can be seen between strobes.

// File: rtl/edid_pkg.sv
package edid_pkg;

    // Fixed addresses and codes used when the top module is built with defaults
    localparam logic [6:0]  EDID_DEV_ADDR   = 7'h50;
    localparam logic [19:0] CAP_BASE_ADDR   = 20'h00000;
    localparam logic [19:0] TREQ_REG_ADDR   = 20'h00218;
    localparam logic [19:0] TCSUM_REG_ADDR  = 20'h00261;
    localparam logic [19:0] TRESP_REG_ADDR  = 20'h00260;
    localparam int          TREQ_EDID_BIT   = 2;
    localparam logic [7:0]  RESP_CSUM_CODE  = 8'h04;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAP,
        ST_EXT,
        ST_BLK,
        ST_CHK,
        ST_TREQ,
        ST_WCSUM,
        ST_WRESP,
        ST_ABORT,
        ST_DONE
    } edid_state_e;

    typedef struct packed {
        logic        req;
        logic        wr;
        logic [19:0] addr;
        logic [7:0]  wdata;
    } aux_cmd_t;

    function automatic logic flag_bit(input logic [7:0] value, input int pos);
        return value[pos[2:0]];
    endfunction

    function automatic logic sum_ok(input logic [7:0] acc);
        return acc == 8'h00;
    endfunction

endpackage

// File: rtl/edid_sum_acc.sv
module edid_sum_acc #(
    parameter  int BLOCK_BYTES = 128,
    localparam int IDX_W       = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add,
    input  logic [7:0]       din,
    output logic [7:0]       sum,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic [7:0]       csum
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

    assign last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum  <= 8'h00;
            idx  <= '0;
            csum <= 8'h00;
        end else if (clr) begin
            sum <= 8'h00;
            idx <= '0;
        end else if (add) begin
            sum <= sum + din;
            idx <= idx + 1'b1;
            if (last) begin
                csum <= din;
            end
        end
    end

endmodule

// File: rtl/edid_try_ctr.sv
module edid_try_ctr #(
    parameter  int MAX_TRIES = 3,
    localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             inc,
    output logic [TRY_W-1:0] count,
    output logic             at_max
);

    localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);

    assign at_max = (count == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= TRY_W'(1);
        end else if (inc && !at_max) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/edid_aux_mux.sv
module edid_aux_mux
    import edid_pkg::*;
#(
    parameter  int          CAP_BYTES  = 12,
    parameter  logic [19:0] CAP_BASE   = CAP_BASE_ADDR,
    parameter  logic [19:0] TREQ_ADDR  = TREQ_REG_ADDR,
    parameter  logic [19:0] TCSUM_ADDR = TCSUM_REG_ADDR,
    parameter  logic [19:0] TRESP_ADDR = TRESP_REG_ADDR,
    parameter  logic [7:0]  RESP_CODE  = RESP_CSUM_CODE,
    localparam int          CAP_W      = $clog2(CAP_BYTES)
) (
    input  edid_state_e      state,
    input  logic [CAP_W-1:0] cap_idx,
    input  logic [7:0]       csum,
    output aux_cmd_t         cmd
);

    always_comb begin
        cmd = '0;
        unique case (state)
            ST_CAP: begin
                cmd.req  = 1'b1;
                cmd.addr = CAP_BASE + 20'(cap_idx);
            end
            ST_TREQ: begin
                cmd.req  = 1'b1;
                cmd.addr = TREQ_ADDR;
            end
            ST_WCSUM: begin
                cmd.req   = 1'b1;
                cmd.wr    = 1'b1;
                cmd.addr  = TCSUM_ADDR;
                cmd.wdata = csum;
            end
            ST_WRESP: begin
                cmd.req   = 1'b1;
                cmd.wr    = 1'b1;
                cmd.addr  = TRESP_ADDR;
                cmd.wdata = RESP_CODE;
            end
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/edid_fetch.sv
module edid_fetch
    import edid_pkg::*;
#(
    parameter  int          BLOCK_BYTES = 128,
    parameter  int          MAX_TRIES   = 3,
    parameter  int          CAP_BYTES   = 12,
    parameter  logic [6:0]  DEV_ADDR    = EDID_DEV_ADDR,
    parameter  logic [19:0] CAP_BASE    = CAP_BASE_ADDR,
    parameter  logic [19:0] TREQ_ADDR   = TREQ_REG_ADDR,
    parameter  logic [19:0] TCSUM_ADDR  = TCSUM_REG_ADDR,
    parameter  logic [19:0] TRESP_ADDR  = TRESP_REG_ADDR,
    parameter  int          TREQ_BIT    = TREQ_EDID_BIT,
    parameter  logic [7:0]  RESP_CODE   = RESP_CSUM_CODE,
    localparam int          IDX_W       = $clog2(BLOCK_BYTES),
    localparam int          OFF_W       = IDX_W + 1,
    localparam int          TRY_W       = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             rd_req,
    output logic [6:0]       rd_dev,
    output logic [OFF_W-1:0] rd_off,
    input  logic [7:0]       rd_data,
    input  logic             rd_err,
    input  logic             rd_done,
    output logic             aux_req,
    output logic             aux_wr,
    output logic [19:0]      aux_addr,
    output logic [7:0]       aux_wdata,
    input  logic [7:0]       aux_rdata,
    input  logic             aux_done,
    output logic             done,
    output logic             pass,
    output logic [TRY_W-1:0] tries,
    output logic [7:0]       csum
);

    localparam int               CAP_W    = $clog2(CAP_BYTES);
    localparam logic [CAP_W-1:0] CAP_LAST = CAP_W'(CAP_BYTES - 1);
    localparam logic [OFF_W-1:0] EXT_OFF  = OFF_W'(BLOCK_BYTES - 2);

    edid_state_e      state_q, state_d;
    logic [CAP_W-1:0] cap_idx_q;
    logic             blk_q;
    logic             ext_q;
    logic             pass_q;
    logic             busy;

    logic cap_rst, cap_inc;
    logic ext_ld;
    logic blk_clr, blk_set;
    logic pass_set, pass_clr;
    logic acc_clr, acc_add;
    logic try_load, try_inc;

    logic [7:0]       acc_sum;
    logic [IDX_W-1:0] acc_idx;
    logic             acc_last;
    logic [7:0]       acc_csum;
    logic             try_at_max;
    aux_cmd_t         aux_cmd;

    assign busy = (state_q != ST_IDLE);

    edid_sum_acc #(
        .BLOCK_BYTES(BLOCK_BYTES)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .clr  (acc_clr),
        .add  (acc_add),
        .din  (rd_data),
        .sum  (acc_sum),
        .idx  (acc_idx),
        .last (acc_last),
        .csum (acc_csum)
    );

    edid_try_ctr #(
        .MAX_TRIES(MAX_TRIES)
    ) u_try (
        .clk    (clk),
        .rst    (rst),
        .load   (try_load),
        .inc    (try_inc),
        .count  (tries),
        .at_max (try_at_max)
    );

    edid_aux_mux #(
        .CAP_BYTES  (CAP_BYTES),
        .CAP_BASE   (CAP_BASE),
        .TREQ_ADDR  (TREQ_ADDR),
        .TCSUM_ADDR (TCSUM_ADDR),
        .TRESP_ADDR (TRESP_ADDR),
        .RESP_CODE  (RESP_CODE)
    ) u_aux (
        .state   (state_q),
        .cap_idx (cap_idx_q),
        .csum    (acc_csum),
        .cmd     (aux_cmd)
    );

    // Sequencer: capability read, then attempts of extension byte + blocks
    always_comb begin
        state_d  = state_q;
        cap_rst  = 1'b0;
        cap_inc  = 1'b0;
        ext_ld   = 1'b0;
        blk_clr  = 1'b0;
        blk_set  = 1'b0;
        pass_set = 1'b0;
        pass_clr = 1'b0;
        acc_clr  = 1'b0;
        acc_add  = 1'b0;
        try_load = 1'b0;
        try_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_CAP;
                    cap_rst  = 1'b1;
                    try_load = 1'b1;
                    pass_clr = 1'b1;
                end
            end
            ST_CAP: begin
                if (aux_done) begin
                    if (cap_idx_q == CAP_LAST) begin
                        state_d = ST_EXT;
                    end else begin
                        cap_inc = 1'b1;
                    end
                end
            end
            ST_EXT: begin
                if (rd_done) begin
                    if (rd_err) begin
                        state_d = ST_ABORT;
                    end else begin
                        ext_ld  = 1'b1;
                        blk_clr = 1'b1;
                        acc_clr = 1'b1;
                        state_d = ST_BLK;
                    end
                end
            end
            ST_BLK: begin
                if (rd_done) begin
                    if (rd_err) begin
                        state_d = ST_ABORT;
                    end else begin
                        acc_add = 1'b1;
                        if (acc_last) begin
                            state_d = ST_CHK;
                        end
                    end
                end
            end
            ST_CHK: begin
                if (!sum_ok(acc_sum)) begin
                    state_d = ST_ABORT;
                end else if (!blk_q && ext_q) begin
                    blk_set = 1'b1;
                    acc_clr = 1'b1;
                    state_d = ST_BLK;
                end else begin
                    state_d = ST_TREQ;
                end
            end
            ST_TREQ: begin
                if (aux_done) begin
                    if (flag_bit(aux_rdata, TREQ_BIT)) begin
                        state_d = ST_WCSUM;
                    end else begin
                        pass_set = 1'b1;
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_WCSUM: begin
                if (aux_done) begin
                    state_d = ST_WRESP;
                end
            end
            ST_WRESP: begin
                if (aux_done) begin
                    pass_set = 1'b1;
                    state_d  = ST_DONE;
                end
            end
            ST_ABORT: begin
                if (try_at_max) begin
                    pass_clr = 1'b1;
                    state_d  = ST_DONE;
                end else begin
                    try_inc = 1'b1;
                    state_d = ST_EXT;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cap_idx_q <= '0;
            blk_q     <= 1'b0;
            ext_q     <= 1'b0;
            pass_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cap_rst) begin
                cap_idx_q <= '0;
            end else if (cap_inc) begin
                cap_idx_q <= cap_idx_q + 1'b1;
            end
            if (ext_ld) begin
                ext_q <= |rd_data;
            end
            if (blk_clr) begin
                blk_q <= 1'b0;
            end else if (blk_set) begin
                blk_q <= 1'b1;
            end
            if (pass_set) begin
                pass_q <= 1'b1;
            end else if (pass_clr) begin
                pass_q <= 1'b0;
            end
        end
    end

    assign rd_req    = (state_q == ST_EXT) || (state_q == ST_BLK);
    assign rd_dev    = DEV_ADDR;
    assign rd_off    = (state_q == ST_EXT) ? EXT_OFF : {blk_q, acc_idx};
    assign aux_req   = aux_cmd.req;
    assign aux_wr    = aux_cmd.wr;
    assign aux_addr  = aux_cmd.addr;
    assign aux_wdata = aux_cmd.wdata;
    assign done      = (state_q == ST_DONE);
    assign pass      = pass_q;
    assign csum      = acc_csum;

endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk #(
    parameter int          MAX_TRIES  = 3,
    parameter int          OFF_W      = 8,
    parameter int          TRY_W      = 2,
    parameter logic [6:0]  DEV_ADDR   = 7'h50,
    parameter logic [19:0] CAP_BASE   = 20'h00000,
    parameter logic [19:0] TCSUM_ADDR = 20'h00261,
    parameter logic [19:0] TRESP_ADDR = 20'h00260
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             rd_req,
    input logic [6:0]       rd_dev,
    input logic [OFF_W-1:0] rd_off,
    input logic             rd_done,
    input logic             aux_req,
    input logic             aux_wr,
    input logic [19:0]      aux_addr,
    input logic             aux_done,
    input logic             done,
    input logic [TRY_W-1:0] tries
);

    // R9
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && aux_req));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_done |=> rd_req && $stable(rd_off));

    // R9
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        aux_req && !aux_done |=> aux_req && $stable(aux_addr) && $stable(aux_wr));

    // R3
    rd_dev_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rd_dev == DEV_ADDR);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    tries_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (tries >= TRY_W'(1)) && (tries <= TRY_W'(MAX_TRIES)));

    // R2
    cap_first_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> aux_req && !aux_wr && aux_addr == CAP_BASE);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        start && busy && !done |=> busy);

    // R7
    resp_after_csum_chk: assert property (@(posedge clk) disable iff (rst)
        aux_req && aux_wr && aux_done && aux_addr == TCSUM_ADDR
        |=> aux_req && aux_wr && aux_addr == TRESP_ADDR);

endmodule

bind edid_fetch edid_fetch_chk #(
    .MAX_TRIES  (MAX_TRIES),
    .OFF_W      (OFF_W),
    .TRY_W      (TRY_W),
    .DEV_ADDR   (DEV_ADDR),
    .CAP_BASE   (CAP_BASE),
    .TCSUM_ADDR (TCSUM_ADDR),
    .TRESP_ADDR (TRESP_ADDR)
) u_edid_fetch_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .rd_req   (rd_req),
    .rd_dev   (rd_dev),
    .rd_off   (rd_off),
    .rd_done  (rd_done),
    .aux_req  (aux_req),
    .aux_wr   (aux_wr),
    .aux_addr (aux_addr),
    .aux_done (aux_done),
    .done     (done),
    .tries    (tries)
);

// File: tb/tb_edid_fetch.sv
`timescale 1ns/1ps
module tb_edid_fetch;

    localparam int BB    = 128;
    localparam int MT    = 3;
    localparam int CB    = 12;
    localparam int OFF_W = 8;
    localparam int TRY_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             rd_req;
    logic [6:0]       rd_dev;
    logic [OFF_W-1:0] rd_off;
    logic [7:0]       rd_data = 8'h00;
    logic             rd_err = 1'b0;
    logic             rd_done = 1'b0;
    logic             aux_req;
    logic             aux_wr;
    logic [19:0]      aux_addr;
    logic [7:0]       aux_wdata;
    logic [7:0]       aux_rdata = 8'h00;
    logic             aux_done = 1'b0;
    logic             done;
    logic             pass;
    logic [TRY_W-1:0] tries;
    logic [7:0]       csum;

    always #2.5 clk = ~clk;

    edid_fetch #(
        .BLOCK_BYTES(BB),
        .MAX_TRIES  (MT),
        .CAP_BYTES  (CB)
    ) dut (
        .clk(clk), .rst(rst), .start(start),
        .rd_req(rd_req), .rd_dev(rd_dev), .rd_off(rd_off),
        .rd_data(rd_data), .rd_err(rd_err), .rd_done(rd_done),
        .aux_req(aux_req), .aux_wr(aux_wr), .aux_addr(aux_addr),
        .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .aux_done(aux_done),
        .done(done), .pass(pass), .tries(tries), .csum(csum)
    );

    int checks = 0;
    int fails  = 0;

    // Sink contents and behaviour knobs
    logic [7:0] mem [0:2*BB-1];
    logic [7:0] treq_val = 8'h00;
    int  err_at  = -1;
    bit  err_all = 1'b0;

    // Observation log
    int rd_total, bad_dev, early_rd, first_off, max_off;
    int cap_reads, cap_first, cap_last, treq_reads, wr_n, done_cnt;
    int wr_addr [0:3];
    int wr_data [0:3];

    bit i2c_busy = 1'b0;
    int i2c_wait = 0;
    bit aux_busy = 1'b0;
    int aux_wait = 0;

    task automatic clear_log();
        rd_total = 0; bad_dev = 0; early_rd = 0; first_off = -1; max_off = -1;
        cap_reads = 0; cap_first = -1; cap_last = -1; treq_reads = 0;
        wr_n = 0; done_cnt = 0;
        err_at = -1; err_all = 1'b0;
    endtask

    // Identification device model: two wait cycles then a done strobe
    always @(negedge clk) begin
        if (rd_done) begin
            rd_done = 1'b0;
            rd_err  = 1'b0;
        end else if (!i2c_busy && rd_req) begin
            i2c_busy = 1'b1;
            i2c_wait = 1;
            if (rd_dev != 7'h50) bad_dev++;
            if (cap_reads < CB) early_rd++;
            if (first_off < 0) first_off = int'(rd_off);
            if (int'(rd_off) > max_off) max_off = int'(rd_off);
        end else if (i2c_busy) begin
            if (i2c_wait > 0) begin
                i2c_wait--;
            end else begin
                rd_done  = 1'b1;
                rd_data  = mem[rd_off];
                rd_err   = err_all || (rd_total == err_at);
                rd_total++;
                i2c_busy = 1'b0;
            end
        end
    end

    // Auxiliary register model
    always @(negedge clk) begin
        if (aux_done) begin
            aux_done = 1'b0;
        end else if (!aux_busy && aux_req) begin
            aux_busy = 1'b1;
            aux_wait = 1;
        end else if (aux_busy) begin
            if (aux_wait > 0) begin
                aux_wait--;
            end else begin
                aux_done = 1'b1;
                aux_busy = 1'b0;
                if (aux_wr) begin
                    if (wr_n < 4) begin
                        wr_addr[wr_n] = int'(aux_addr);
                        wr_data[wr_n] = int'(aux_wdata);
                    end
                    wr_n++;
                end else if (aux_addr == 20'h00218) begin
                    aux_rdata = treq_val;
                    treq_reads++;
                end else begin
                    aux_rdata = 8'hA5 ^ aux_addr[7:0];
                    if (cap_reads == 0) cap_first = int'(aux_addr);
                    cap_last = int'(aux_addr);
                    cap_reads++;
                end
            end
        end
    end

    always @(negedge clk) if (done) done_cnt++;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Build a block whose byte sum wraps to zero, optionally spoiled afterwards
    task automatic fill(input int blk, input logic [7:0] ext, input bit spoil);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < BB - 1; i++) begin
            logic [7:0] b = 8'(i * 7 + blk * 13 + 1);
            if (blk == 0 && i == BB - 2) b = ext;
            mem[blk * BB + i] = b;
            s = s + b;
        end
        mem[blk * BB + BB - 1] = 8'(8'h00 - s);
        if (spoil) mem[blk * BB + 5] = mem[blk * BB + 5] ^ 8'h01;
    endtask

    int got_pass, got_tries, got_csum;

    task automatic run(input int extra_start);
        bit seen = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            start = (c == extra_start);
            if (done) begin
                got_pass  = int'(pass);
                got_tries = int'(tries);
                got_csum  = int'(csum);
                seen = 1'b1;
                break;
            end
        end
        start = 1'b0;
        chk("R8", "sequence completed", int'(seen), 1);
        repeat (10) @(negedge clk);
        chk("R8", "single done pulse", done_cnt, 1);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "pass after reset", int'(pass), 0);
        chk("R1", "rd_req after reset", int'(rd_req), 0);
        chk("R1", "aux_req after reset", int'(aux_req), 0);
        chk("R1", "tries after reset", int'(tries), 0);
    endtask

    task automatic t_basic();
        clear_log();
        fill(0, 8'h00, 1'b0);
        treq_val = 8'hFB;
        run(40);
        chk("R2", "capability reads", cap_reads, CB);
        chk("R2", "capability first addr", cap_first, 0);
        chk("R2", "capability last addr", cap_last, CB - 1);
        chk("R2", "reads before capability done", early_rd, 0);
        chk("R3", "device address errors", bad_dev, 0);
        chk("R3", "first offset", first_off, BB - 2);
        chk("R4", "pass", got_pass, 1);
        chk("R5", "highest offset no extension", max_off, BB - 1);
        chk("R10", "reads with stray start", rd_total, 1 + BB);
        chk("R8", "tries", got_tries, 1);
        chk("R8", "csum byte", got_csum, int'(mem[BB - 1]));
        chk("R7", "test-request reads", treq_reads, 1);
        chk("R7", "writes with bit 2 clear", wr_n, 0);
        chk("R1", "idle after done", int'(rd_req) + int'(aux_req), 0);
    endtask

    task automatic t_ext_treq();
        clear_log();
        fill(0, 8'h03, 1'b0);
        fill(1, 8'h00, 1'b0);
        treq_val = 8'h04;
        run(-1);
        chk("R5", "pass with extension", got_pass, 1);
        chk("R5", "reads with extension", rd_total, 1 + 2 * BB);
        chk("R5", "highest offset", max_off, 2 * BB - 1);
        chk("R8", "csum of extension block", got_csum, int'(mem[2 * BB - 1]));
        chk("R7", "write count", wr_n, 2);
        chk("R7", "first write addr", wr_addr[0], 'h261);
        chk("R7", "first write data", wr_data[0], int'(mem[2 * BB - 1]));
        chk("R7", "second write addr", wr_addr[1], 'h260);
        chk("R7", "second write data", wr_data[1], 'h04);
    endtask

    task automatic t_noext_treq();
        clear_log();
        fill(0, 8'h00, 1'b0);
        treq_val = 8'h04;
        run(-1);
        chk("R7", "pass", got_pass, 1);
        chk("R7", "write count", wr_n, 2);
        chk("R7", "csum write uses base block", wr_data[0], int'(mem[BB - 1]));
    endtask

    task automatic t_bad_sum();
        clear_log();
        fill(0, 8'h00, 1'b1);
        treq_val = 8'h04;
        run(-1);
        chk("R4", "bad sum fails", got_pass, 0);
        chk("R6", "attempts used", got_tries, MT);
        chk("R6", "reads over all attempts", rd_total, MT * (1 + BB));
        chk("R2", "capability once per start", cap_reads, CB);
        chk("R7", "no test-request read on fail", treq_reads, 0);
        chk("R7", "no writes on fail", wr_n, 0);
    endtask

    task automatic t_err_retry();
        clear_log();
        fill(0, 8'h00, 1'b0);
        treq_val = 8'h00;
        err_at = 5;
        run(-1);
        chk("R6", "pass after retry", got_pass, 1);
        chk("R6", "attempts used", got_tries, 2);
        chk("R6", "reads", rd_total, 6 + 1 + BB);
    endtask

    task automatic t_ext_err();
        clear_log();
        fill(0, 8'h01, 1'b0);
        fill(1, 8'h00, 1'b0);
        treq_val = 8'h00;
        err_at = 1 + BB + 10;
        run(-1);
        chk("R5", "pass after extension error", got_pass, 1);
        chk("R6", "attempts used", got_tries, 2);
        chk("R6", "reads", rd_total, (2 + BB + 10) + 1 + 2 * BB);
    endtask

    task automatic t_ext_bad();
        clear_log();
        fill(0, 8'h02, 1'b0);
        fill(1, 8'h00, 1'b1);
        treq_val = 8'h04;
        run(-1);
        chk("R5", "bad extension fails", got_pass, 0);
        chk("R6", "attempts used", got_tries, MT);
        chk("R6", "reads", rd_total, MT * (1 + 2 * BB));
        chk("R8", "last csum byte", got_csum, int'(mem[2 * BB - 1]));
        chk("R7", "no writes", wr_n, 0);
    endtask

    task automatic t_err_all();
        clear_log();
        fill(0, 8'h00, 1'b0);
        err_all = 1'b1;
        run(-1);
        chk("R6", "read errors fail", got_pass, 0);
        chk("R6", "attempts used", got_tries, MT);
        chk("R3", "only extension byte read per attempt", rd_total, MT);
        chk("R3", "offset of aborted attempts", max_off, BB - 2);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_log();
        t_reset();
        t_basic();
        t_ext_treq();
        t_noext_treq();
        t_bad_sum();
        t_err_retry();
        t_ext_err();
        t_ext_bad();
        t_err_all();
        finish_run();
    end

endmodule